// File: doc/BRIEF.md
# Eight-Channel Output Fault Guard

This block sits between the serial command register and the eight switched output drivers. It combines three conditions into the enable that reaches each driver: the commanded state, that channel's overtemperature flag, and a global supply-overvoltage flag. Thermal shutdown acts on one channel only and releases by itself when the channel cools. An overvoltage turns every channel off, and the commanded pattern comes back when the supply recovers. Both paths are combinational, so shutdown does not wait for a clock edge.

It also keeps an 8-bit fault register that the serial block reads. A channel's bit is set by that channel's overtemperature. It is also set by an open-load indication, but only while the channel is commanded off and no blanking window is running. Each chip-select rising edge starts a blanking window of `BLANK_CYC` clock cycles, so that switching transients are not reported as faults. Fault bits are sticky. They clear when the serial block takes its status snapshot at the start of a frame, and any fault still present at that moment is loaded again.

Top module: `chan_fault_guard`

## Requirements
- R1: `out_en[i]` is 1 exactly when `cmd[i]` is 1, `otemp[i]` is 0 and `ovolt` is 0. It follows these inputs in the same cycle, with no clock edge involved.
- R2: When `otemp[i]` is 1, `out_en[i]` is 0 and every other channel's enable is unaffected. At the next clock edge, `fault_reg[i]` becomes 1.
- R3: When `otemp[i]` returns to 0 while `cmd[i]` is still 1, `out_en[i]` returns to 1 on its own.
- R4: While `ovolt` is 1, all eight enables are 0. When `ovolt` falls, `out_en` equals `cmd` again. Overvoltage does not set fault bits.
- R5: `open_raw[i]` can set `fault_reg[i]` only while `cmd[i]` is 0. For a commanded-on channel, the open-load indication is ignored.
- R6: A clock edge that samples `cs_rise` high, together with the following `BLANK_CYC` edges, ignores `open_raw`. The first edge after that window latches it.
- R7: A `cs_rise` during an active window restarts the full `BLANK_CYC` window from that edge.
- R8: Once set, a fault bit stays 1 after its cause is removed, until an edge samples `snap_load` high.
- R9: An edge that samples `snap_load` high replaces `fault_reg` with the faults present in that same cycle. Conditions that have cleared drop out; conditions still present stay set.
- R10: After reset, `fault_reg` is 0 and no blanking window is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 8 | Commanded on/off state per channel |
| open_raw | input | 8 | Raw open-load comparator result per channel |
| otemp | input | 8 | Overtemperature flag per channel |
| ovolt | input | 1 | Global supply-overvoltage flag |
| cs_rise | input | 1 | One-cycle pulse on chip-select rising edge |
| snap_load | input | 1 | One-cycle pulse when the status snapshot is taken |
| out_en | output | 8 | Effective enable per output driver |
| fault_reg | output | 8 | Latched fault bits for the serial block |

## Verification
The enable path has no registers, so the R1–R4 enable checks sample `out_en` 1 ns after the inputs change, in the same cycle and well before the next edge. Fault bits pass through one register: the bench drives a cause, advances exactly one edge, and then reads `fault_reg`.

The blanking checks count edges from the one that sampled `cs_rise`. They require the bit to stay clear after each of the next `BLANK_CYC` edges and to set after the following one, so a window that is one cycle short or one cycle long is caught.

// File: rtl/chan_fault_guard_pkg.sv
package chan_fault_guard_pkg;

  localparam int unsigned NCH = 8;

  typedef logic [NCH-1:0] chan_t;

  // driver enable: command gated by per-channel thermal and global supply state
  function automatic chan_t gate_enable(chan_t cmd, chan_t otemp, logic ovolt);
    return cmd & ~otemp & {NCH{~ovolt}};
  endfunction

  // open-load indication only counts for channels held off, outside blanking
  function automatic chan_t qualify_open(chan_t open_raw, chan_t cmd, logic blanked);
    return open_raw & ~cmd & {NCH{~blanked}};
  endfunction

endpackage

// File: rtl/fp_blank_timer.sv
module fp_blank_timer #(
  parameter int unsigned BLANK_CYC = 16,
  localparam int unsigned CW = $clog2(BLANK_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [CW-1:0] count
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(BLANK_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign busy  = (cnt_q != '0);
  assign count = cnt_q;

endmodule

// File: rtl/fp_fault_bit.sv
module fp_fault_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic cause,
  input  logic reload,
  output logic flag
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (reload) begin
      flag_q <= cause;
    end else begin
      flag_q <= flag_q | cause;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/fp_enable_gate.sv
module fp_enable_gate
  import chan_fault_guard_pkg::*;
(
  input  chan_t cmd,
  input  chan_t otemp,
  input  logic  ovolt,
  output chan_t en
);

  assign en = gate_enable(cmd, otemp, ovolt);

endmodule

// File: rtl/chan_fault_guard.sv
module chan_fault_guard
  import chan_fault_guard_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 16,
  localparam int unsigned CNT_W = $clog2(BLANK_CYC + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cmd,
  input  logic [NCH-1:0] open_raw,
  input  logic [NCH-1:0] otemp,
  input  logic           ovolt,
  input  logic           cs_rise,
  input  logic           snap_load,
  output logic [NCH-1:0] out_en,
  output logic [NCH-1:0] fault_reg
);

  // named internal events, visible to the bound checker
  logic             blank_busy;
  logic [CNT_W-1:0] blank_cnt;
  logic             blank_now;
  chan_t            open_ok;
  chan_t            fault_cause;

  fp_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cs_rise),
    .busy  (blank_busy),
    .count (blank_cnt)
  );

  // the edge that sees the chip-select pulse is itself blanked
  assign blank_now   = blank_busy | cs_rise;
  assign open_ok     = qualify_open(open_raw, cmd, blank_now);
  assign fault_cause = open_ok | otemp;

  fp_enable_gate u_gate (
    .cmd   (cmd),
    .otemp (otemp),
    .ovolt (ovolt),
    .en    (out_en)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_fault
    fp_fault_bit u_bit (
      .clk    (clk),
      .rst_n  (rst_n),
      .cause  (fault_cause[ch]),
      .reload (snap_load),
      .flag   (fault_reg[ch])
    );
  end

endmodule

// File: rtl/chan_fault_guard_chk.sv
module chan_fault_guard_chk
  import chan_fault_guard_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 16,
  parameter int unsigned CW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] cmd,
  input logic [NCH-1:0] open_raw,
  input logic [NCH-1:0] otemp,
  input logic           ovolt,
  input logic           cs_rise,
  input logic           snap_load,
  input logic [NCH-1:0] out_en,
  input logic [NCH-1:0] fault_reg,
  input logic           blank_busy,
  input logic [CW-1:0]  blank_cnt
);

  // R4
  ovolt_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovolt |-> (out_en == '0));

  // R2
  hot_chan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en & otemp) == '0);

  // R1
  never_uncommanded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en & ~cmd) == '0);

  // R8
  sticky_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_load |=> ((fault_reg & $past(fault_reg)) == $past(fault_reg)));

  // R5
  open_needs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_load |=> ((fault_reg & ~$past(fault_reg) & ~$past(otemp) & $past(cmd)) == '0));

  // R6
  blank_ignores_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap_load && (blank_busy || cs_rise)) |=>
      ((fault_reg & ~$past(fault_reg) & ~$past(otemp)) == '0));

  // R7
  blank_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (blank_cnt == CW'(BLANK_CYC)));

endmodule

bind chan_fault_guard chan_fault_guard_chk #(
  .BLANK_CYC (BLANK_CYC),
  .CW        (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd        (cmd),
  .open_raw   (open_raw),
  .otemp      (otemp),
  .ovolt      (ovolt),
  .cs_rise    (cs_rise),
  .snap_load  (snap_load),
  .out_en     (out_en),
  .fault_reg  (fault_reg),
  .blank_busy (blank_busy),
  .blank_cnt  (blank_cnt)
);

// File: tb/chan_fault_guard_tb.sv
`timescale 1ns/1ps
module chan_fault_guard_tb;

  localparam int BLANK = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cmd = '0, open_raw = '0, otemp = '0;
  logic       ovolt = 1'b0, cs_rise = 1'b0, snap_load = 1'b0;
  logic [7:0] out_en, fault_reg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chan_fault_guard #(.BLANK_CYC(BLANK)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .open_raw  (open_raw),
    .otemp     (otemp),
    .ovolt     (ovolt),
    .cs_rise   (cs_rise),
    .snap_load (snap_load),
    .out_en    (out_en),
    .fault_reg (fault_reg)
  );

  // bench model of the enable rule
  function automatic logic [7:0] exp_en(logic [7:0] c, logic [7:0] t, logic v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = c[i] && !t[i] && !v;
    return r;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // advance one edge, land 2 ns after it
  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic snap();
    snap_load = 1'b1;
    tick();
    snap_load = 1'b0;
  endtask

  task automatic pulse_cs();
    cs_rise = 1'b1;
    tick();
    cs_rise = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 fault after reset", fault_reg, 8'h00);
    open_raw = 8'h01;
    tick();
    check("R10 no blanking after reset", fault_reg, 8'h01);
    open_raw = 8'h00;
    snap();
    check("R9 snapshot clears", fault_reg, 8'h00);
  endtask

  task automatic t_enable();
    cmd = 8'hA5; settle();
    check("R1 pattern A5", out_en, exp_en(cmd, otemp, ovolt));
    cmd = 8'h3C; settle();
    check("R1 pattern 3C", out_en, exp_en(cmd, otemp, ovolt));
    cmd = 8'hFF; settle();
    check("R1 pattern FF", out_en, 8'hFF);
  endtask

  task automatic t_thermal();
    cmd = 8'hFF; otemp = 8'h08; settle();
    check("R2 only hot channel off", out_en, 8'hF7);
    tick();
    check("R2 thermal fault bit", fault_reg, 8'h08);
    otemp = 8'h00; settle();
    check("R3 auto recovery", out_en, 8'hFF);
    tick(3);
    check("R8 fault stays latched", fault_reg, 8'h08);
    snap();
    check("R9 cleared condition dropped", fault_reg, 8'h00);
  endtask

  task automatic t_ovolt();
    cmd = 8'h5A; ovolt = 1'b1; settle();
    check("R4 all off", out_en, 8'h00);
    tick();
    check("R4 no fault from overvoltage", fault_reg, 8'h00);
    ovolt = 1'b0; settle();
    check("R4 restore commanded", out_en, 8'h5A);
  endtask

  task automatic t_open_on();
    cmd = 8'hFF; open_raw = 8'hFF;
    tick(3);
    check("R5 ignored when commanded on", fault_reg, 8'h00);
    cmd = 8'h0F;
    tick();
    check("R5 latched when commanded off", fault_reg, 8'hF0);
    open_raw = 8'h00;
    snap();
    check("R9 clear after open removed", fault_reg, 8'h00);
  endtask

  task automatic t_blank();
    cmd = 8'h00; open_raw = 8'h00;
    pulse_cs();
    open_raw = 8'h01;
    tick(BLANK);
    check("R6 blanked for window", fault_reg, 8'h00);
    tick();
    check("R6 latched after window", fault_reg, 8'h01);
    open_raw = 8'h00;
    snap();
    check("R9 clear after blank test", fault_reg, 8'h00);
  endtask

  task automatic t_restart();
    cmd = 8'h00; open_raw = 8'h02;
    pulse_cs();
    tick(10);
    check("R6 inside first window", fault_reg, 8'h00);
    pulse_cs();
    tick(BLANK);
    check("R7 window restarted", fault_reg, 8'h00);
    tick();
    check("R7 latched after restarted window", fault_reg, 8'h02);
  endtask

  task automatic t_rearm();
    // open_raw 02 still present with cmd 0
    snap();
    check("R9 present fault reloaded", fault_reg, 8'h02);
    open_raw = 8'h00; otemp = 8'h40;
    snap();
    check("R9 reload with thermal only", fault_reg, 8'h40);
    otemp = 8'h00;
    snap();
    check("R9 all clear", fault_reg, 8'h00);
  endtask

  initial begin
    #25;
    rst_n = 1'b1;
    tick();
    t_reset();
    t_enable();
    t_thermal();
    t_ovolt();
    t_open_on();
    t_blank();
    t_restart();
    t_rearm();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule